// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter with a parameterised width; the default is four bits, which gives a modulo-16 count. On each rising clock edge it does one of four things. It clears, loads a parallel word, increments, or keeps its value. A fixed priority decides which one happens. An active-low load input takes the parallel word. Two count enables must both be high for the counter to advance. The terminal-count flag is gated only by the second enable, called the chain enable.

Stages cascade by wiring the terminal-count output of one stage to the chain enable of the next. All stages share the clock and the plain count enable, so a wide counter built this way advances on the same edge everywhere. A loadable stage of this kind also serves as a programmable divider.

A build-time parameter picks the reset style:
- An asynchronous active-low clear, which acts at once without a clock edge.
- A synchronous active-low clear, which acts only on a rising edge.

Top module: `presettable_counter`

## Requirements
- R1: With reset and load inactive (loadN high) and both `cntEnable` and `chainEnable` high, each rising edge adds one to `countOut`, and the all-ones value (15 for WIDTH=4) wraps to 0.
- R2: With ASYNC_RESET=1, a low `rstN` forces `countOut` to 0 at once, without waiting for a clock edge, and keeps it there whatever the other inputs do.
- R3: With ASYNC_RESET=0, a low `rstN` leaves `countOut` unchanged between edges and clears it to 0 on the next rising edge.
- R4: With reset inactive and `loadN` low, a rising edge copies `dataIn` into `countOut`, whatever the values of both enables.
- R5: With reset inactive, `loadN` high and `cntEnable` low, `countOut` holds its value across rising edges.
- R6: With reset inactive, `loadN` high and `chainEnable` low, `countOut` holds its value across rising edges.
- R7: `termCount` is high exactly when `countOut` is all ones and `chainEnable` is high. It follows `chainEnable` combinationally, and `cntEnable` has no effect on it.
- R8: Reset takes priority over load. A low `rstN` on the same edge as a low `loadN` leaves `countOut` at 0, not at `dataIn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low clear; its style is set by ASYNC_RESET |
| loadN | input | 1 | Active-low parallel load strobe |
| dataIn | input | WIDTH | Parallel load word |
| cntEnable | input | 1 | Count enable shared by all stages |
| chainEnable | input | 1 | Count enable that also gates termCount; driven by the previous stage's termCount |
| countOut | output | WIDTH | Current count |
| termCount | output | 1 | High when the count is all ones and chainEnable is high |

## Verification
The bench drives both reset variants side by side. It drops reset in the middle of a clock period and checks two things:
- The asynchronous copy clears at once. A design that waited for the edge would still show the loaded value.
- The synchronous copy keeps its value until the next edge. A design that cleared early would break this.

Reset is also asserted together with a load. A design that ranked load above reset would show the loaded word instead of zero.

At count 15 the bench toggles `chainEnable` with no clock edge and flips `cntEnable`. This exposes a terminal-count flag that was registered, not gated, or that wrongly depended on the shared enable.

The bench also checks the wrap from 15 to 0, a load made while both enables are high, and a hold with each enable low in turn. These catch a wrong modulus, a load ranked below count, and enable logic that uses an OR where an AND is needed.

// File: rtl/presettable_counter_pkg.sv
package presettable_counter_pkg;

  // Per-edge action chosen by the control decode; reset is applied in the datapath.
  typedef struct packed {
    logic load;
    logic incr;
  } cnt_strobe_t;

endpackage

// File: rtl/presettable_counter_ctrl.sv
module presettable_counter_ctrl
  import presettable_counter_pkg::*;
(
  input  logic        loadN,
  input  logic        cntEnable,
  input  logic        chainEnable,
  input  logic        countAtMax,
  output cnt_strobe_t strobe,
  output logic        termCount
);

  // Load outranks counting; counting needs both enables.
  always_comb begin
    strobe.load = ~loadN;
    strobe.incr = loadN & cntEnable & chainEnable;
  end

  // Terminal count is gated by the chain enable only, without a register.
  assign termCount = countAtMax & chainEnable;

endmodule

// File: rtl/presettable_counter_dp.sv
module presettable_counter_dp
  import presettable_counter_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dataIn,
  input  cnt_strobe_t      strobe,
  output logic [WIDTH-1:0] countOut,
  output logic             countAtMax
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] countQ;
  logic [WIDTH-1:0] countNext;

  always_comb begin
    if (strobe.load)      countNext = dataIn;
    else if (strobe.incr) countNext = countQ + ONE;
    else                  countNext = countQ;
  end

  generate
    if (ASYNC_RESET) begin : g_async
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) countQ <= '0;
        else       countQ <= countNext;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) countQ <= '0;
        else       countQ <= countNext;
      end
    end
  endgenerate

  assign countOut   = countQ;
  assign countAtMax = (countQ == ALL_ONES);

endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import presettable_counter_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadN,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             cntEnable,
  input  logic             chainEnable,
  output logic [WIDTH-1:0] countOut,
  output logic             termCount
);

  cnt_strobe_t strobe;
  logic        countAtMax;

  presettable_counter_ctrl i_ctrl (
    .loadN       (loadN),
    .cntEnable   (cntEnable),
    .chainEnable (chainEnable),
    .countAtMax  (countAtMax),
    .strobe      (strobe),
    .termCount   (termCount)
  );

  presettable_counter_dp #(
    .WIDTH       (WIDTH),
    .ASYNC_RESET (ASYNC_RESET)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .dataIn     (dataIn),
    .strobe     (strobe),
    .countOut   (countOut),
    .countAtMax (countAtMax)
  );

endmodule

// File: rtl/presettable_counter_chk.sv
module presettable_counter_chk #(
  parameter int WIDTH       = 4,
  parameter bit ASYNC_RESET = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic             loadN,
  input logic [WIDTH-1:0] dataIn,
  input logic             cntEnable,
  input logic             chainEnable,
  input logic [WIDTH-1:0] countOut,
  input logic             termCount
);

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic rstSeenQ = 1'b1;
  always @(posedge clk) rstSeenQ <= rstN;

  AST_INCR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && cntEnable && chainEnable) |=> (countOut == $past(countOut) + ONE)) // R1
    else $error("AST_INCR_WRAP");

  always @(negedge clk) begin
    if (ASYNC_RESET && !rstN) begin
      AST_ASYNC_CLEAR: assert (countOut == '0) else $error("AST_ASYNC_CLEAR"); // R2
    end
  end

  AST_RESET_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (!rstSeenQ) |-> (countOut == '0)) // R3
    else $error("AST_RESET_EDGE");

  AST_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (!loadN) |=> (countOut == $past(dataIn))) // R4
    else $error("AST_LOAD");

  AST_HOLD_CNT: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && !cntEnable) |=> $stable(countOut)) // R5
    else $error("AST_HOLD_CNT");

  AST_HOLD_CHAIN: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && !chainEnable) |=> $stable(countOut)) // R6
    else $error("AST_HOLD_CHAIN");

  AST_TC_GATE: assert property (@(posedge clk) disable iff (!rstN)
    termCount |-> (chainEnable && (&countOut))) // R7
    else $error("AST_TC_GATE");

endmodule

bind presettable_counter presettable_counter_chk #(
  .WIDTH       (WIDTH),
  .ASYNC_RESET (ASYNC_RESET)
) u_chk (.*);

// File: tb/test_presettable_counter.sv
module test_presettable_counter;

  localparam int CLK_PERIOD = 10;
  localparam int WIDTH      = 4;

  logic             clk = 1'b0;
  logic             rstN;
  logic             loadN;
  logic [WIDTH-1:0] dataIn;
  logic             cntEnable;
  logic             chainEnable;
  logic [WIDTH-1:0] cntA, cntS;
  logic             tcA, tcS;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  presettable_counter #(.WIDTH(WIDTH), .ASYNC_RESET(1'b1)) i_presettable_counter (
    .clk(clk), .rstN(rstN), .loadN(loadN), .dataIn(dataIn),
    .cntEnable(cntEnable), .chainEnable(chainEnable),
    .countOut(cntA), .termCount(tcA)
  );

  presettable_counter #(.WIDTH(WIDTH), .ASYNC_RESET(1'b0)) i_presettable_counter_sync (
    .clk(clk), .rstN(rstN), .loadN(loadN), .dataIn(dataIn),
    .cntEnable(cntEnable), .chainEnable(chainEnable),
    .countOut(cntS), .termCount(tcS)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkBoth(input string req, input int exp);
    check({req, " async"}, int'(cntA), exp);
    check({req, " sync"},  int'(cntS), exp);
  endtask

  task automatic edgeStep();
    @(posedge clk);
    #1;
  endtask

  task automatic doLoad(input int val, input logic ce, input logic ch);
    loadN = 1'b0; dataIn = WIDTH'(val); cntEnable = ce; chainEnable = ch;
    edgeStep();
    loadN = 1'b1;
  endtask

  task automatic testResetState();
    rstN = 1'b0; loadN = 1'b1; dataIn = '0; cntEnable = 1'b0; chainEnable = 1'b0;
    edgeStep(); edgeStep();
    checkBoth("R2/R3 reset state", 0);
    check("R7 tc after reset", int'(tcA), 0);
    rstN = 1'b1;
  endtask

  task automatic testLoadAndWrap();
    doLoad(13, 1'b0, 1'b0);
    checkBoth("R4 load with enables low", 13);
    cntEnable = 1'b1; chainEnable = 1'b1;
    edgeStep();
    checkBoth("R1 count 14", 14);
    edgeStep();
    checkBoth("R1 count 15", 15);
    check("R7 tc at 15", int'(tcA), 1);
    edgeStep();
    checkBoth("R1 wrap to 0", 0);
    check("R7 tc low at 0", int'(tcS), 0);
    edgeStep();
    checkBoth("R1 count after wrap", 1);
  endtask

  task automatic testHold();
    doLoad(5, 1'b1, 1'b1);
    checkBoth("R4 load beats enables", 5);
    cntEnable = 1'b0; chainEnable = 1'b1;
    edgeStep(); edgeStep();
    checkBoth("R5 hold cntEnable low", 5);
    cntEnable = 1'b1; chainEnable = 1'b0;
    edgeStep(); edgeStep();
    checkBoth("R6 hold chainEnable low", 5);
    chainEnable = 1'b1;
    edgeStep();
    checkBoth("R1 resume count", 6);
  endtask

  task automatic testTermCountGate();
    doLoad(15, 1'b0, 1'b0);
    cntEnable = 1'b1; chainEnable = 1'b0;
    #1;
    check("R7 tc gated off by chainEnable", int'(tcA), 0);
    edgeStep();
    checkBoth("R6 hold at 15", 15);
    chainEnable = 1'b1; cntEnable = 1'b0;
    #1;
    check("R7 tc follows chainEnable without edge", int'(tcA), 1);
    check("R7 tc sync variant", int'(tcS), 1);
    cntEnable = 1'b1;
    #1;
    check("R7 tc unaffected by cntEnable", int'(tcA), 1);
    cntEnable = 1'b0;
    edgeStep();
    checkBoth("R5 hold at 15", 15);
  endtask

  task automatic testResetOverLoad();
    rstN = 1'b0; loadN = 1'b0; dataIn = 4'd9; cntEnable = 1'b1; chainEnable = 1'b1;
    edgeStep();
    checkBoth("R8 reset beats load", 0);
    rstN = 1'b1; loadN = 1'b1; cntEnable = 1'b0; chainEnable = 1'b0;
  endtask

  task automatic testMidCycleReset();
    doLoad(7, 1'b0, 1'b0);
    checkBoth("R4 load 7", 7);
    #2;
    rstN = 1'b0;
    #1;
    check("R2 async clears mid-cycle", int'(cntA), 0);
    check("R3 sync waits for edge", int'(cntS), 7);
    edgeStep();
    check("R3 sync clears on edge", int'(cntS), 0);
    rstN = 1'b1;
  endtask

  initial begin
    testResetState();
    testLoadAndWrap();
    testHold();
    testTermCountGate();
    testResetOverLoad();
    testMidCycleReset();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule